// File: doc/BRIEF.md
# SD Card Data FIFO with Transfer Sequencer

This block sits between a word-wide register port and the serialiser that drives an SD card's data lines. It buffers up to sixteen 32-bit words in a FIFO. Software reaches the FIFO through one data register select. The line side is modelled as a word source (card to host) and a word sink (host to card), each with a valid/ready handshake. Bit serialisation and CRC16 are not modelled.

Software loads a block size in bytes and a block count, then starts a read or a write through the control select. A sequencer counts words inside each block and blocks inside the transfer. It latches a block interrupt at every block boundary and returns to data mode when the last block completes. One packed debug word reports several fields together: the sequencer state code, the FIFO fill level, and the two programmable thresholds. Writing the same word with its force bit set pulls a stalled transfer back to data mode. A status word holds a data-request flag, a sticky FIFO-misuse flag and the block interrupt.

Register selects (`reg_sel`): 0 data, 1 debug, 2 block size (bytes), 3 block count (9 bits), 4 status, 5 control. Control bit 0 starts a read and bit 1 starts a write; bit 0 wins when both are set.

Top module: `sd_data_fifo`

## Requirements
- R1: After reset, the debug word reads 0x0001_0800. That value means state 0, fill 0, and both thresholds 4. The status word, `data_req`, `src_ready` and `snk_valid` all read 0.
- R2: The FIFO holds up to 16 words and returns them in the order written. Its fill level reads back in debug bits 8:4.
- R3: Some data accesses are misuse. A data read while the FIFO is empty, or while a write transfer is active, returns 0 and removes nothing. A data write while the FIFO is full, or while a read transfer is active, is dropped. Each misuse sets status bit 3 from the next cycle.
- R4: Writing the status select clears status bit 3 and bit 9 where the written bit is 1. Written zeros leave those bits unchanged.
- R5: The write threshold sits in debug bits 13:9 and the read threshold in bits 18:14. Both are written through the debug select and read back there.
- R6: The data request flag appears on `data_req` and on status bit 0. During a read transfer (states 2, 4, 5) it is 1 when fill ≥ read threshold. During a write transfer (states 3, 6, 7, 0xa) it is 1 when fill ≤ write threshold. In every other state it is 0.
- R7: A read transfer uses debug bits 3:0 as follows. It runs in state 2 and accepts source words while the FIFO is not full. It moves to state 4 while the FIFO is full. It spends one cycle in state 5 after each block's last word. After the final block it ends in state 1.
- R8: A write transfer begins in state 0xa and waits there until the FIFO holds a word. It then sends words from state 3. If the FIFO empties mid-block it moves to state 7. It spends one cycle in state 6 after each block's last word, then returns to 0xa, or to 1 after the final block.
- R9: Words per block is block size divided by 4, with a minimum of 1. Each block end sets status bit 9. A start with block count 0 goes straight to state 1 and moves no words.
- R10: Writing the debug select with bit 19 set forces the state to 1 when the state is 2, 4 or 0xa. In any other state the bit has no effect. Bit 19 always reads 0.
- R11: A start written while the state is neither 0 nor 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO on the data select) |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from the select |
| src_valid | input | 1 | Card-side word available |
| src_data | input | DW | Card-side word |
| src_ready | output | 1 | FIFO accepts a card-side word |
| snk_valid | output | 1 | Word offered to the line serialiser |
| snk_data | output | DW | Word offered to the line serialiser |
| snk_ready | input | 1 | Serialiser takes the word |
| data_req | output | 1 | Data request flag |
| blk_irq | output | 1 | Latched block interrupt (status bit 9) |
| fifo_err | output | 1 | Latched FIFO misuse (status bit 3) |

## Verification
Register read data is combinational, so a read returns the state left by the previous clock edge. Pushes, pops, state changes and status flags take effect one edge after the accepting cycle. The block interrupt and the misuse flag are visible on the cycle that follows the offending or final word. The bench drives every access at a falling edge and samples 1 ns later. Before reading state or level, it idles enough whole cycles for every pending handshake to drain, so each expected value sits at a settled point and never at the edge that produces it.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

  typedef enum logic [3:0] {
    XS_IDENT    = 4'h0,
    XS_DATA     = 4'h1,
    XS_RDATA    = 4'h2,
    XS_WDATA    = 4'h3,
    XS_RWAIT    = 4'h4,
    XS_RCRC     = 4'h5,
    XS_WCRC     = 4'h6,
    XS_WWAIT1   = 4'h7,
    XS_PDOWN    = 4'h8,
    XS_PUP      = 4'h9,
    XS_WSTART1  = 4'hA,
    XS_WSTART2  = 4'hB,
    XS_GENPULSE = 4'hC,
    XS_WWAIT2   = 4'hD,
    XS_SPDOWN   = 4'hF
  } xstate_e;

  typedef enum logic [2:0] {
    SEL_DATA  = 3'd0,
    SEL_DBG   = 3'd1,
    SEL_BSIZE = 3'd2,
    SEL_BCNT  = 3'd3,
    SEL_STAT  = 3'd4,
    SEL_CTRL  = 3'd5
  } rsel_e;

  localparam int FLD_W         = 5;
  localparam int DBG_FILL_LSB  = 4;
  localparam int DBG_WTHR_LSB  = 9;
  localparam int DBG_RTHR_LSB  = 14;
  localparam int DBG_FORCE_BIT = 19;
  localparam int STAT_DREQ     = 0;
  localparam int STAT_ERR      = 3;
  localparam int STAT_BLK      = 9;

  function automatic logic is_rd_grp(input xstate_e s);
    return (s == XS_RDATA) || (s == XS_RWAIT) || (s == XS_RCRC);
  endfunction

  function automatic logic is_wr_grp(input xstate_e s);
    return (s == XS_WDATA) || (s == XS_WWAIT1) || (s == XS_WCRC) || (s == XS_WSTART1);
  endfunction

  function automatic logic dreq_calc(input xstate_e s, input logic [FLD_W-1:0] lvl,
                                     input logic [FLD_W-1:0] wthr, input logic [FLD_W-1:0] rthr);
    if (is_rd_grp(s)) return lvl >= rthr;
    if (is_wr_grp(s)) return lvl <= wthr;
    return 1'b0;
  endfunction

  function automatic logic [31:0] pack_dbg(input xstate_e s, input logic [FLD_W-1:0] lvl,
                                           input logic [FLD_W-1:0] wthr, input logic [FLD_W-1:0] rthr);
    logic [31:0] v;
    v = '0;
    v[3:0] = s;
    v[DBG_FILL_LSB +: FLD_W] = lvl;
    v[DBG_WTHR_LSB +: FLD_W] = wthr;
    v[DBG_RTHR_LSB +: FLD_W] = rthr;
    return v;
  endfunction

endpackage

// File: rtl/sdf_fifo.sv
module sdf_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic [DW-1:0]    pop_data,
  output logic [LVL_W-1:0] lvl,
  output logic             full,
  output logic             empty
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full     = (lvl == LVL_W'(DEPTH));
  assign empty    = (lvl == '0);
  assign pop_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      lvl  <= '0;
    end else begin
      if (push) wptr <= ptr_next(wptr);
      if (pop)  rptr <= ptr_next(rptr);
      case ({push, pop})
        2'b10:   lvl <= lvl + LVL_W'(1);
        2'b01:   lvl <= lvl - LVL_W'(1);
        default: lvl <= lvl;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end
endmodule

// File: rtl/sdf_xfer_ctl.sv
module sdf_xfer_ctl
  import sdf_pkg::*;
#(
  parameter int BSZ_W  = 12,
  parameter int BCNT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_rd,
  input  logic              start_wr,
  input  logic              force_dm,
  input  logic [BSZ_W-1:0]  bsize,
  input  logic [BCNT_W-1:0] bcount,
  input  logic              full,
  input  logic              empty,
  input  logic              src_valid,
  input  logic              snk_ready,
  output logic              src_ready,
  output logic              snk_valid,
  output logic              src_fire,
  output logic              snk_fire,
  output logic              blk_evt,
  output xstate_e           state
);
  xstate_e           nxt;
  logic [BSZ_W-1:0]  wcnt;
  logic [BCNT_W-1:0] blk_left;
  logic              idle, start_ok, word_fire;

  function automatic logic [BSZ_W-1:0] words_per_block(input logic [BSZ_W-1:0] b);
    logic [BSZ_W-1:0] w;
    w = b >> 2;
    return (w == '0) ? BSZ_W'(1) : w;
  endfunction

  assign idle      = (state == XS_IDENT) || (state == XS_DATA);
  assign start_ok  = idle && (start_rd || start_wr);
  assign src_ready = (state == XS_RDATA) && !full;
  assign snk_valid = (state == XS_WDATA) && !empty;
  assign src_fire  = src_valid && src_ready;
  assign snk_fire  = snk_valid && snk_ready;
  assign word_fire = src_fire || snk_fire;
  assign blk_evt   = word_fire && (wcnt == words_per_block(bsize) - BSZ_W'(1));

  always_comb begin
    nxt = state;
    case (state)
      XS_IDENT, XS_DATA: begin
        if (start_rd)      nxt = (bcount == '0) ? XS_DATA : XS_RDATA;
        else if (start_wr) nxt = (bcount == '0) ? XS_DATA : XS_WSTART1;
      end
      XS_RDATA: begin
        if (force_dm)     nxt = XS_DATA;
        else if (blk_evt) nxt = XS_RCRC;
        else if (full)    nxt = XS_RWAIT;
      end
      XS_RWAIT: begin
        if (force_dm)   nxt = XS_DATA;
        else if (!full) nxt = XS_RDATA;
      end
      XS_RCRC: nxt = (blk_left == '0) ? XS_DATA : XS_RDATA;
      XS_WSTART1: begin
        if (force_dm)    nxt = XS_DATA;
        else if (!empty) nxt = XS_WDATA;
      end
      XS_WDATA: begin
        if (blk_evt)    nxt = XS_WCRC;
        else if (empty) nxt = XS_WWAIT1;
      end
      XS_WWAIT1: if (!empty) nxt = XS_WDATA;
      XS_WCRC:   nxt = (blk_left == '0) ? XS_DATA : XS_WSTART1;
      default:   nxt = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= XS_IDENT;
      wcnt     <= '0;
      blk_left <= '0;
    end else begin
      state <= nxt;
      if (start_ok) begin
        wcnt     <= '0;
        blk_left <= bcount;
      end else if (blk_evt) begin
        wcnt     <= '0;
        blk_left <= blk_left - BCNT_W'(1);
      end else if (word_fire) begin
        wcnt <= wcnt + BSZ_W'(1);
      end
    end
  end
endmodule

// File: rtl/sd_data_fifo.sv
module sd_data_fifo
  import sdf_pkg::*;
#(
  parameter int DW     = 32,
  parameter int DEPTH  = 16,
  parameter int BSZ_W  = 12,
  parameter int BCNT_W = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  output logic          src_ready,
  output logic          snk_valid,
  output logic [DW-1:0] snk_data,
  input  logic          snk_ready,
  output logic          data_req,
  output logic          blk_irq,
  output logic          fifo_err
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  rsel_e             sel;
  xstate_e           state;
  logic [LVL_W-1:0]  lvl;
  logic [FLD_W-1:0]  lvl_f, wthr, rthr;
  logic [BSZ_W-1:0]  bsize_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic              full, empty, push, pop, src_fire, snk_fire, blk_evt;
  logic              hit_data, data_wr_ok, data_rd_ok, err_evt;
  logic              force_dm, start_rd, start_wr, st_wr, st_err, st_blk;
  logic [DW-1:0]     fifo_out, push_data;

  assign sel        = rsel_e'(reg_sel);
  assign hit_data   = (sel == SEL_DATA);
  assign data_wr_ok = reg_wr && hit_data && !full && !is_rd_grp(state);
  assign data_rd_ok = reg_rd && hit_data && !empty && !is_wr_grp(state);
  assign err_evt    = (reg_wr && hit_data && !data_wr_ok) || (reg_rd && hit_data && !data_rd_ok);
  assign push       = src_fire || data_wr_ok;
  assign push_data  = src_fire ? src_data : reg_wdata;
  assign pop        = snk_fire || data_rd_ok;
  assign snk_data   = fifo_out;
  assign force_dm   = reg_wr && (sel == SEL_DBG) && reg_wdata[DBG_FORCE_BIT];
  assign start_rd   = reg_wr && (sel == SEL_CTRL) && reg_wdata[0];
  assign start_wr   = reg_wr && (sel == SEL_CTRL) && reg_wdata[1] && !reg_wdata[0];
  assign st_wr      = reg_wr && (sel == SEL_STAT);
  assign lvl_f      = FLD_W'(lvl);
  assign data_req   = dreq_calc(state, lvl_f, wthr, rthr);
  assign blk_irq    = st_blk;
  assign fifo_err   = st_err;

  sdf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(fifo_out), .lvl(lvl), .full(full), .empty(empty)
  );

  sdf_xfer_ctl #(.BSZ_W(BSZ_W), .BCNT_W(BCNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .start_wr(start_wr), .force_dm(force_dm),
    .bsize(bsize_q), .bcount(bcnt_q), .full(full), .empty(empty), .src_valid(src_valid),
    .snk_ready(snk_ready), .src_ready(src_ready), .snk_valid(snk_valid), .src_fire(src_fire),
    .snk_fire(snk_fire), .blk_evt(blk_evt), .state(state)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wthr    <= FLD_W'(4);
      rthr    <= FLD_W'(4);
      bsize_q <= '0;
      bcnt_q  <= '0;
      st_err  <= 1'b0;
      st_blk  <= 1'b0;
    end else begin
      if (reg_wr && sel == SEL_DBG) begin
        wthr <= reg_wdata[DBG_WTHR_LSB +: FLD_W];
        rthr <= reg_wdata[DBG_RTHR_LSB +: FLD_W];
      end
      if (reg_wr && sel == SEL_BSIZE) bsize_q <= reg_wdata[BSZ_W-1:0];
      if (reg_wr && sel == SEL_BCNT)  bcnt_q  <= reg_wdata[BCNT_W-1:0];
      st_err <= err_evt || (st_err && !(st_wr && reg_wdata[STAT_ERR]));
      st_blk <= blk_evt || (st_blk && !(st_wr && reg_wdata[STAT_BLK]));
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_DATA:  reg_rdata = data_rd_ok ? fifo_out : '0;
      SEL_DBG:   reg_rdata = DW'(pack_dbg(state, lvl_f, wthr, rthr));
      SEL_BSIZE: reg_rdata = DW'(bsize_q);
      SEL_BCNT:  reg_rdata = DW'(bcnt_q);
      SEL_STAT: begin
        reg_rdata[STAT_DREQ] = data_req;
        reg_rdata[STAT_ERR]  = st_err;
        reg_rdata[STAT_BLK]  = st_blk;
      end
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sd_data_fifo_chk.sv
module sd_data_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       state,
  input logic [LVL_W-1:0] lvl,
  input logic             push,
  input logic             pop,
  input logic             err_evt,
  input logic             blk_evt,
  input logic             st_err,
  input logic             st_blk,
  input logic             snk_valid,
  input logic             src_ready
);
  // R2
  lvl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) lvl <= LVL_W'(DEPTH));
  // R2
  lvl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (lvl == $past(lvl) + LVL_W'(1)));
  // R3
  err_latch_chk: assert property (@(posedge clk) disable iff (!rst_n) err_evt |=> st_err);
  // R9
  blk_latch_chk: assert property (@(posedge clk) disable iff (!rst_n) blk_evt |=> st_blk);
  // R7
  rcrc_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'h5) |=> (state != 4'h5));
  // R8
  sink_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snk_valid |-> (state == 4'h3) && (lvl != '0));
  // R7
  src_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (state == 4'h2) && (lvl < LVL_W'(DEPTH)));
endmodule

bind sd_data_fifo sd_data_fifo_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .lvl(lvl), .push(push), .pop(pop),
  .err_evt(err_evt), .blk_evt(blk_evt), .st_err(st_err), .st_blk(st_blk),
  .snk_valid(snk_valid), .src_ready(src_ready)
);

// File: tb/tb_sd_data_fifo.sv
`timescale 1ns/1ps
module tb_sd_data_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        src_valid = 1'b0, src_ready;
  logic [31:0] src_data = '0, snk_data;
  logic        snk_valid, snk_ready = 1'b0;
  logic        data_req, blk_irq, fifo_err;

  int checks = 0, fails = 0;
  logic [31:0] mq[$];
  logic [31:0] got[$];
  logic [31:0] sent[$];

  always #2.5 clk = ~clk;

  sd_data_fifo dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .snk_valid(snk_valid), .snk_data(snk_data), .snk_ready(snk_ready),
    .data_req(data_req), .blk_irq(blk_irq), .fifo_err(fifo_err)
  );

  always @(posedge clk) if (rst_n && snk_valid && snk_ready) got.push_back(snk_data);

  function automatic logic [31:0] dbg(input int st, input int fill, input int w, input int r);
    return 32'(st) | (32'(fill) << 4) | (32'(w) << 9) | (32'(r) << 14);
  endfunction

  function automatic logic [31:0] thr(input int w, input int r);
    return (32'(w) << 9) | (32'(r) << 14);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1; #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic push_m(input logic [31:0] w);
    wr_reg(3'd0, w); mq.push_back(w);
  endtask

  task automatic pop_chk(input string req);
    logic [31:0] d, e;
    rd_reg(3'd0, d);
    e = mq.pop_front();
    chk(req, d, e);
  endtask

  task automatic src_send(input logic [31:0] w);
    @(negedge clk); src_valid = 1'b1; src_data = w;
    while (!src_ready) @(negedge clk);
    @(posedge clk); #1 src_valid = 1'b0;
    mq.push_back(w);
  endtask

  task automatic rd_chk(input string req, input logic [2:0] s, input logic [31:0] exp);
    logic [31:0] d;
    rd_reg(s, d);
    chk(req, d, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int unsigned seed_v;
    seed_v = $urandom(32'h00C0FFEE);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    // R1 reset values
    chk("R1 data_req", 32'(data_req), 0);
    chk("R1 src_ready", 32'(src_ready), 0);
    chk("R1 snk_valid", 32'(snk_valid), 0);
    rd_chk("R1 debug", 3'd1, 32'h0001_0800);
    rd_chk("R1 status", 3'd4, 32'h0);

    // R2 random fill and drain in idle state
    for (int r = 0; r < 5; r++) begin
      int n;
      n = 1 + int'($urandom % 16);
      for (int i = 0; i < n; i++) push_m($urandom);
      rd_chk("R2 fill", 3'd1, dbg(0, n, 4, 4));
      for (int i = 0; i < n; i++) pop_chk("R2 order");
    end

    // R3 overfill, R4 clear
    for (int i = 0; i < 16; i++) push_m($urandom);
    wr_reg(3'd0, 32'hDEAD_BEEF);
    rd_chk("R3 full drop", 3'd1, dbg(0, 16, 4, 4));
    rd_chk("R3 full err", 3'd4, 32'h8);
    for (int i = 0; i < 16; i++) pop_chk("R3 order after drop");
    wr_reg(3'd4, 32'h8);
    rd_chk("R4 clear err", 3'd4, 32'h0);
    rd_chk("R3 empty read zero", 3'd0, 32'h0);
    rd_chk("R3 empty err", 3'd4, 32'h8);
    wr_reg(3'd4, 32'h0);
    rd_chk("R4 zero keeps", 3'd4, 32'h8);
    wr_reg(3'd4, 32'h8);
    rd_chk("R4 clear again", 3'd4, 32'h0);

    // R5 thresholds
    wr_reg(3'd1, thr(3, 6));
    rd_chk("R5 thresholds", 3'd1, dbg(0, 0, 3, 6));

    // R8 write transfer: 16 bytes x 2 blocks
    wr_reg(3'd2, 32'd16);
    wr_reg(3'd3, 32'd2);
    wr_reg(3'd5, 32'h2);
    idle(1);
    rd_chk("R8 start state", 3'd1, dbg(10, 0, 3, 6));
    chk("R6 write dreq low fill", 32'(data_req), 1);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] w; w = $urandom; wr_reg(3'd0, w); sent.push_back(w);
    end
    idle(1);
    rd_chk("R8 sending state", 3'd1, dbg(3, 4, 3, 6));
    chk("R6 write dreq above thr", 32'(data_req), 0);
    wr_reg(3'd1, (32'h1 << 19) | thr(3, 6));
    idle(1);
    rd_chk("R10 force ignored in 3", 3'd1, dbg(3, 4, 3, 6));
    snk_ready = 1'b1;
    idle(8);
    rd_chk("R8 next block start", 3'd1, dbg(10, 0, 3, 6));
    rd_chk("R9 block irq", 3'd4, 32'h201);
    rd_chk("R3 read in write xfer", 3'd0, 32'h0);
    rd_chk("R3 err in write xfer", 3'd4, 32'h209);
    wr_reg(3'd4, 32'h208);
    for (int i = 0; i < 2; i++) begin
      logic [31:0] w; w = $urandom; wr_reg(3'd0, w); sent.push_back(w);
    end
    idle(6);
    rd_chk("R8 mid-block wait", 3'd1, dbg(7, 0, 3, 6));
    for (int i = 0; i < 2; i++) begin
      logic [31:0] w; w = $urandom; wr_reg(3'd0, w); sent.push_back(w);
    end
    idle(6);
    rd_chk("R8 end state", 3'd1, dbg(1, 0, 3, 6));
    rd_chk("R9 final block irq", 3'd4, 32'h200);
    chk("R9 blk_irq pin", 32'(blk_irq), 1);
    chk("R8 word count", 32'(got.size()), 8);
    for (int i = 0; i < 8; i++) chk("R2 sink order", got[i], sent[i]);
    wr_reg(3'd4, 32'h208);
    snk_ready = 1'b0;

    // R7 read transfer: 8 bytes x 3 blocks
    wr_reg(3'd1, thr(3, 3));
    wr_reg(3'd2, 32'd8);
    wr_reg(3'd3, 32'd3);
    wr_reg(3'd5, 32'h1);
    idle(1);
    rd_chk("R7 start state", 3'd1, dbg(2, 0, 3, 3));
    for (int i = 0; i < 4; i++) src_send($urandom);
    idle(2);
    rd_chk("R7 receiving", 3'd1, dbg(2, 4, 3, 3));
    chk("R6 read dreq", 32'(data_req), 1);
    rd_chk("R9 read block irq", 3'd4, 32'h201);
    wr_reg(3'd0, 32'h1234_5678);
    rd_chk("R3 write dropped in read", 3'd1, dbg(2, 4, 3, 3));
    rd_chk("R3 err in read xfer", 3'd4, 32'h209);
    wr_reg(3'd4, 32'h208);
    for (int i = 0; i < 4; i++) pop_chk("R2 read order");
    rd_chk("R6 read dreq low", 3'd4, 32'h0);
    for (int i = 0; i < 2; i++) src_send($urandom);
    idle(3);
    rd_chk("R7 end state", 3'd1, dbg(1, 2, 3, 3));
    for (int i = 0; i < 2; i++) pop_chk("R2 read tail");
    wr_reg(3'd4, 32'h208);

    // R7 read wait, R11, R10
    wr_reg(3'd2, 32'd128);
    wr_reg(3'd3, 32'd1);
    wr_reg(3'd5, 32'h1);
    for (int i = 0; i < 16; i++) src_send($urandom);
    idle(2);
    rd_chk("R7 read wait", 3'd1, dbg(4, 16, 3, 3));
    chk("R7 src_ready full", 32'(src_ready), 0);
    wr_reg(3'd5, 32'h2);
    idle(1);
    rd_chk("R11 start ignored", 3'd1, dbg(4, 16, 3, 3));
    wr_reg(3'd1, (32'h1 << 19) | thr(3, 3));
    idle(1);
    rd_chk("R10 force to data", 3'd1, dbg(1, 16, 3, 3));
    for (int i = 0; i < 16; i++) pop_chk("R2 drain after force");

    // R9 zero block count
    wr_reg(3'd3, 32'd0);
    wr_reg(3'd5, 32'h1);
    idle(1);
    rd_chk("R9 zero count", 3'd1, dbg(1, 0, 3, 3));
    chk("R9 zero count src_ready", 32'(src_ready), 0);

    // R9 block size below one word
    wr_reg(3'd2, 32'd2);
    wr_reg(3'd3, 32'd2);
    wr_reg(3'd5, 32'h1);
    for (int i = 0; i < 2; i++) src_send($urandom);
    idle(3);
    rd_chk("R9 small block end", 3'd1, dbg(1, 2, 3, 3));
    rd_chk("R9 small block irq", 3'd4, 32'h200);
    for (int i = 0; i < 2; i++) pop_chk("R2 small block data");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule